// File: doc/BRIEF.md
# Request/Acknowledge Parallel Handshake Engine

This block moves data words between an on-chip FIFO and an external parallel device using a request line and an acknowledge line. It can run in either direction. When data flows in, the device drives the request and the engine answers with the acknowledge. When data flows out, the engine drives the request and the device answers with the acknowledge. The FIFO sits on the other side, and the engine pushes words into it or pops words from it.

There are two handshake flavours. In streaming (burst) flavour, one word moves on every cycle where the selected transfer clock enable is high, as long as both lines are active. In single-exchange flavour, each full request/acknowledge cycle moves exactly one word, and the transfer clock enable is not used. Each line can be set to active high or active low. The two device-driven lines are re-timed by a two-flop synchronizer before the engine acts on them.

Top module: `reqack_xfer_engine`

## Requirements
- R1: While reset is held, both engine-driven lines sit at their inactive level (equal to their polarity bit) and neither fifo_push_o nor fifo_pop_o is asserted.
- R2: A change on dev_req_i or dev_ack_i passes through two synchronizer flops. The engine line that responds to it first changes after the third rising clock edge following the change.
- R3: With cfg_dir=0 (device to FIFO) and cfg_emul=0 (burst), eng_ack_o is active while the synchronized request is active and fifo_full_i is low. One word is pushed on each cycle where xfer_tick is high, the request is active and eng_ack_o is active.
- R4: With cfg_dir=0 and cfg_emul=0, a full FIFO stops pushes and drops eng_ack_o on the next edge. The flow resumes once space returns.
- R5: With cfg_dir=1 (FIFO to device) and cfg_emul=0, eng_req_o is active while fifo_empty_i is low. One word is popped on each cycle where xfer_tick is high, eng_req_o is active and the synchronized acknowledge is active.
- R6: With cfg_dir=1 and cfg_emul=0, an empty FIFO drops eng_req_o on the next edge.
- R7: With cfg_dir=0 and cfg_emul=1 (single exchange), an active request with room in the FIFO pushes exactly one word and raises eng_ack_o. The acknowledge stays active until the request is released. A new word is taken only after that release.
- R8: With cfg_dir=1 and cfg_emul=1, eng_req_o rises when a word is available. The synchronized acknowledge pops exactly one word and drops eng_req_o. The engine then waits for the acknowledge to be released before it starts another exchange.
- R9: cfg_req_low=1 makes both request lines active low, and cfg_ack_low=1 makes both acknowledge lines active low. A value of 0 makes the line active high.
- R10: In single-exchange flavour, xfer_tick has no effect, and exchanges complete with it held low.
- R11: fifo_wdata_o carries ext_data_i in the cycle of a push. ext_data_o shows fifo_rdata_i when cfg_dir=1 and zero when cfg_dir=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir | input | 1 | 0: device to FIFO, 1: FIFO to device |
| cfg_emul | input | 1 | 0: burst streaming, 1: single word per exchange |
| cfg_req_low | input | 1 | Request polarity, 1 = active low |
| cfg_ack_low | input | 1 | Acknowledge polarity, 1 = active low |
| xfer_tick | input | 1 | Selected transfer clock enable for burst flavour |
| dev_req_i | input | 1 | Request from device (inbound direction) |
| eng_ack_o | output | 1 | Acknowledge to device (inbound direction) |
| eng_req_o | output | 1 | Request to device (outbound direction) |
| dev_ack_i | input | 1 | Acknowledge from device (outbound direction) |
| ext_data_i | input | DATA_W | Data from device |
| ext_data_o | output | DATA_W | Data to device |
| fifo_push_o | output | 1 | Write strobe into the FIFO |
| fifo_wdata_o | output | DATA_W | Word written into the FIFO |
| fifo_full_i | input | 1 | FIFO has no room |
| fifo_pop_o | output | 1 | Read strobe from the FIFO |
| fifo_rdata_i | input | DATA_W | Head word of the FIFO (show-ahead) |
| fifo_empty_i | input | 1 | FIFO holds no word |

## Verification
Inbound burst traffic is driven first with a constant tick and then with an alternating tick. This shows that words are paced by the tick and not by the clock, and filling the FIFO shows the stall and the restart. Outbound burst traffic drains a preloaded FIFO, which shows the request falling when the FIFO runs empty and the data order on the pins. Single-exchange runs hold a request or acknowledge for many cycles and then release and re-assert it. This separates one word per exchange from one word per cycle. Runs with both polarities set active low show that the inversion is applied on every handshake pin.

// File: rtl/reqack_pkg.sv
package reqack_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_REL  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   line;
    } hs_state_t;

endpackage

// File: rtl/reqack_sync.sv
module reqack_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= rst_val;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= rst_val;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/reqack_hs_core.sv
module reqack_hs_core
    import reqack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_dir,
    input  logic cfg_emul,
    input  logic req_act,
    input  logic ack_act,
    input  logic xfer_tick,
    input  logic fifo_full_i,
    input  logic fifo_empty_i,
    output logic line_o,
    output logic push_o,
    output logic pop_o
);

    hs_state_t st_q, st_d;
    logic      push_d, pop_d;

    always_comb begin
        st_d   = st_q;
        push_d = 1'b0;
        pop_d  = 1'b0;
        if (!cfg_dir) begin
            if (!cfg_emul) begin
                st_d.phase = PH_IDLE;
                st_d.line  = req_act && !fifo_full_i;
                push_d     = st_q.line && req_act && xfer_tick && !fifo_full_i;
            end else begin
                case (st_q.phase)
                    PH_IDLE: begin
                        st_d.line = 1'b0;
                        if (req_act && !fifo_full_i) begin
                            push_d     = 1'b1;
                            st_d.line  = 1'b1;
                            st_d.phase = PH_HOLD;
                        end
                    end
                    PH_HOLD: begin
                        if (!req_act) begin
                            st_d.line  = 1'b0;
                            st_d.phase = PH_IDLE;
                        end
                    end
                    default: begin
                        st_d.line  = 1'b0;
                        st_d.phase = PH_IDLE;
                    end
                endcase
            end
        end else begin
            if (!cfg_emul) begin
                st_d.phase = PH_IDLE;
                st_d.line  = !fifo_empty_i;
                pop_d      = st_q.line && ack_act && xfer_tick && !fifo_empty_i;
            end else begin
                case (st_q.phase)
                    PH_IDLE: begin
                        st_d.line = 1'b0;
                        if (!fifo_empty_i) begin
                            st_d.line  = 1'b1;
                            st_d.phase = PH_HOLD;
                        end
                    end
                    PH_HOLD: begin
                        if (ack_act) begin
                            pop_d      = !fifo_empty_i;
                            st_d.line  = 1'b0;
                            st_d.phase = PH_REL;
                        end
                    end
                    PH_REL: begin
                        st_d.line = 1'b0;
                        if (!ack_act) st_d.phase = PH_IDLE;
                    end
                    default: begin
                        st_d.line  = 1'b0;
                        st_d.phase = PH_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, line: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
    assign push_o = push_d;
    assign pop_o  = pop_d;

    // R7: a single exchange never pushes on two cycles in a row
    a_r7_one_push_per_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_emul && !cfg_dir && push_o) |=> !push_o);

    // R8: the pop of a single exchange withdraws the request
    a_r8_pop_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_emul && cfg_dir && pop_o) |=> !line_o);

    // R4: a full FIFO withdraws the burst acknowledge
    a_r4_full_stalls_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_emul && !cfg_dir && fifo_full_i) |=> !line_o);

    // R6: an empty FIFO withdraws the burst request
    a_r6_empty_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_emul && cfg_dir && fifo_empty_i) |=> !line_o);

endmodule

// File: rtl/reqack_xfer_engine.sv
module reqack_xfer_engine #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dir,
    input  logic              cfg_emul,
    input  logic              cfg_req_low,
    input  logic              cfg_ack_low,
    input  logic              xfer_tick,
    input  logic              dev_req_i,
    output logic              eng_ack_o,
    output logic              eng_req_o,
    input  logic              dev_ack_i,
    input  logic [DATA_W-1:0] ext_data_i,
    output logic [DATA_W-1:0] ext_data_o,
    output logic              fifo_push_o,
    output logic [DATA_W-1:0] fifo_wdata_o,
    input  logic              fifo_full_i,
    output logic              fifo_pop_o,
    input  logic [DATA_W-1:0] fifo_rdata_i,
    input  logic              fifo_empty_i
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] idle_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               req_act;
    logic               ack_act;
    logic               line;

    assign raw_lines  = {dev_ack_i, dev_req_i};
    assign idle_lines = {cfg_ack_low, cfg_req_low};

    reqack_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (idle_lines),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    assign req_act = sync_lines[0] ^ cfg_req_low;
    assign ack_act = sync_lines[1] ^ cfg_ack_low;

    reqack_hs_core core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_dir      (cfg_dir),
        .cfg_emul     (cfg_emul),
        .req_act      (req_act),
        .ack_act      (ack_act),
        .xfer_tick    (xfer_tick),
        .fifo_full_i  (fifo_full_i),
        .fifo_empty_i (fifo_empty_i),
        .line_o       (line),
        .push_o       (fifo_push_o),
        .pop_o        (fifo_pop_o)
    );

    assign eng_ack_o    = (!cfg_dir && line) ^ cfg_ack_low;
    assign eng_req_o    = (cfg_dir && line) ^ cfg_req_low;
    assign fifo_wdata_o = ext_data_i;
    assign ext_data_o   = cfg_dir ? fifo_rdata_i : '0;

endmodule

// File: tb/reqack_xfer_engine_tb_top.sv
module reqack_xfer_engine_tb_top;

    localparam int W   = 16;
    localparam int CAP = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         cfg_dir = 1'b0, cfg_emul = 1'b0, cfg_req_low = 1'b0, cfg_ack_low = 1'b0;
    logic         tick = 1'b0, dev_req = 1'b0, dev_ack = 1'b0;
    logic [W-1:0] din = '0;
    logic         fifo_full = 1'b0, fifo_empty = 1'b1;
    logic [W-1:0] rdata = '0;
    logic         eng_ack, eng_req, push, pop;
    logic [W-1:0] dout, wdata;

    reqack_xfer_engine #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_emul(cfg_emul),
        .cfg_req_low(cfg_req_low), .cfg_ack_low(cfg_ack_low), .xfer_tick(tick),
        .dev_req_i(dev_req), .eng_ack_o(eng_ack), .eng_req_o(eng_req), .dev_ack_i(dev_ack),
        .ext_data_i(din), .ext_data_o(dout), .fifo_push_o(push), .fifo_wdata_o(wdata),
        .fifo_full_i(fifo_full), .fifo_pop_o(pop), .fifo_rdata_i(rdata),
        .fifo_empty_i(fifo_empty)
    );

    logic [W-1:0] rxq[$];
    logic [W-1:0] txq[$];
    int    checks = 0, failures = 0, cycles = 0;
    int    push_cnt = 0, pop_cnt = 0;
    string cur_tag = "R1";
    int    m_rs1, m_rs2, m_as1, m_as2, m_phase, m_line;

    function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endfunction

    function automatic void refresh();
        fifo_full  = (rxq.size() >= CAP);
        fifo_empty = (txq.size() == 0);
        rdata      = fifo_empty ? '0 : txq[0];
    endfunction

    function automatic void model_out(output bit p, output bit q);
        bit ra, aa;
        ra = (m_rs2 != 0) ^ cfg_req_low;
        aa = (m_as2 != 0) ^ cfg_ack_low;
        p = 0; q = 0;
        if (!cfg_dir) begin
            if (!cfg_emul) p = (m_line != 0) && ra && tick && !fifo_full;
            else           p = (m_phase == 0) && ra && !fifo_full;
        end else begin
            if (!cfg_emul) q = (m_line != 0) && aa && tick && !fifo_empty;
            else           q = (m_phase == 1) && aa && !fifo_empty;
        end
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit ra, aa;
        if (!rst_n) begin
            m_rs1 = cfg_req_low; m_rs2 = cfg_req_low;
            m_as1 = cfg_ack_low; m_as2 = cfg_ack_low;
            m_phase = 0; m_line = 0;
        end else begin
            ra = (m_rs2 != 0) ^ cfg_req_low;
            aa = (m_as2 != 0) ^ cfg_ack_low;
            if (!cfg_emul) begin
                m_phase = 0;
                m_line  = cfg_dir ? int'(!fifo_empty) : int'(ra && !fifo_full);
            end else if (!cfg_dir) begin
                if (m_phase == 0) begin
                    m_line = 0;
                    if (ra && !fifo_full) begin m_line = 1; m_phase = 1; end
                end else if (!ra) begin
                    m_line = 0; m_phase = 0;
                end
            end else begin
                if (m_phase == 0) begin
                    m_line = 0;
                    if (!fifo_empty) begin m_line = 1; m_phase = 1; end
                end else if (m_phase == 1) begin
                    if (aa) begin m_line = 0; m_phase = 2; end
                end else begin
                    m_line = 0;
                    if (!aa) m_phase = 0;
                end
            end
            m_rs2 = m_rs1; m_rs1 = dev_req;
            m_as2 = m_as1; m_as1 = dev_ack;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        bit ep, eq;
        @(negedge clk);
        if (rst_n) begin
            model_out(ep, eq);
            chk(push == ep, cur_tag, "push", push, ep);
            chk(pop == eq, cur_tag, "pop", pop, eq);
            chk(eng_ack == ((!cfg_dir && m_line != 0) ^ cfg_ack_low), cur_tag, "eng_ack", eng_ack,
                (!cfg_dir && m_line != 0) ^ cfg_ack_low);
            chk(eng_req == ((cfg_dir && m_line != 0) ^ cfg_req_low), cur_tag, "eng_req", eng_req,
                (cfg_dir && m_line != 0) ^ cfg_req_low);
            chk(dout == (cfg_dir ? rdata : '0), "R11", "ext_data_o", dout, cfg_dir ? rdata : '0);
            if (push) begin
                chk(wdata == din, "R11", "fifo_wdata_o", wdata, din);
                rxq.push_back(wdata);
                push_cnt++;
            end
            if (pop && txq.size() > 0) begin
                void'(txq.pop_front());
                pop_cnt++;
            end
        end
        refresh();
    endtask

    task automatic do_reset(bit dir, bit emul, bit rl, bit al);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dir = dir; cfg_emul = emul; cfg_req_low = rl; cfg_ack_low = al;
        dev_req = rl; dev_ack = al; tick = 1'b0; din = '0;
        rxq.delete(); txq.delete();
        push_cnt = 0; pop_cnt = 0;
        refresh();
        repeat (2) @(negedge clk);
        chk(eng_ack == al, "R1", "reset eng_ack", eng_ack, al);
        chk(eng_req == rl, "R1", "reset eng_req", eng_req, rl);
        chk(push == 1'b0 && pop == 1'b0, "R1", "reset strobes", {push, pop}, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        // inbound burst: synchronizer latency, streaming, full stall
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R3";
        dev_req = 1'b1; tick = 1'b1; din = 16'h0a00;
        step(); chk(eng_ack == 1'b0, "R2", "ack after 1 edge", eng_ack, 0); din++;
        step(); chk(eng_ack == 1'b0, "R2", "ack after 2 edges", eng_ack, 0); din++;
        step(); chk(eng_ack == 1'b1, "R2", "ack after 3 edges", eng_ack, 1); din++;
        for (int i = 0; i < 9; i++) begin step(); din++; end
        chk(push_cnt == CAP, "R4", "pushes until full", push_cnt, CAP);
        chk(eng_ack == 1'b0, "R4", "ack dropped when full", eng_ack, 0);
        rxq.delete(); refresh();
        for (int i = 0; i < 3; i++) begin step(); din++; end
        chk(push_cnt >= CAP + 1, "R4", "flow resumes", push_cnt, CAP + 1);
        rxq.delete(); refresh(); push_cnt = 0;
        for (int i = 0; i < 8; i++) begin tick = (i % 2 == 1); step(); din++; end
        chk(push_cnt == 4, "R3", "pushes paced by tick", push_cnt, 4);

        // outbound burst
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        cur_tag = "R5";
        for (int i = 0; i < 5; i++) txq.push_back(W'(16'h0100 + i));
        refresh();
        dev_ack = 1'b1; tick = 1'b1;
        step(); chk(eng_req == 1'b1, "R5", "req with data", eng_req, 1);
        for (int i = 0; i < 9; i++) step();
        chk(pop_cnt == 5, "R5", "all words popped", pop_cnt, 5);
        chk(eng_req == 1'b0, "R6", "req dropped when empty", eng_req, 0);

        // inbound single exchange, tick held low
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        cur_tag = "R7";
        tick = 1'b0; dev_req = 1'b1; din = 16'h5a5a;
        for (int i = 0; i < 10; i++) step();
        chk(push_cnt == 1, "R10", "one word without tick", push_cnt, 1);
        chk(eng_ack == 1'b1, "R7", "ack held", eng_ack, 1);
        dev_req = 1'b0;
        for (int i = 0; i < 5; i++) step();
        chk(eng_ack == 1'b0, "R7", "ack released", eng_ack, 0);
        dev_req = 1'b1; din = 16'h1234;
        for (int i = 0; i < 6; i++) step();
        chk(push_cnt == 2, "R7", "second exchange", push_cnt, 2);

        // outbound single exchange
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        cur_tag = "R8";
        for (int i = 0; i < 3; i++) txq.push_back(W'(16'h0c00 + i));
        refresh();
        for (int i = 0; i < 4; i++) step();
        chk(eng_req == 1'b1, "R8", "req raised", eng_req, 1);
        dev_ack = 1'b1;
        for (int i = 0; i < 6; i++) step();
        chk(pop_cnt == 1, "R8", "one pop per ack", pop_cnt, 1);
        chk(eng_req == 1'b0, "R8", "req dropped", eng_req, 0);
        for (int i = 0; i < 4; i++) step();
        chk(pop_cnt == 1, "R8", "waits ack release", pop_cnt, 1);
        dev_ack = 1'b0;
        for (int i = 0; i < 6; i++) step();
        chk(eng_req == 1'b1, "R8", "new exchange", eng_req, 1);
        dev_ack = 1'b1;
        for (int i = 0; i < 6; i++) step();
        chk(pop_cnt == 2, "R8", "second pop", pop_cnt, 2);

        // active-low polarity on both lines
        do_reset(1'b0, 1'b0, 1'b1, 1'b1);
        cur_tag = "R9";
        dev_req = 1'b0; tick = 1'b1; din = 16'h0077;
        for (int i = 0; i < 5; i++) begin step(); din++; end
        chk(eng_ack == 1'b0, "R9", "active-low ack asserted", eng_ack, 0);
        chk(push_cnt > 0, "R9", "pushes with active-low request", push_cnt, 1);
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        txq.push_back(16'h0e01); txq.push_back(16'h0e02); refresh();
        dev_ack = 1'b0; tick = 1'b1;
        for (int i = 0; i < 7; i++) step();
        chk(pop_cnt == 2, "R9", "pops with active-low ack", pop_cnt, 2);
        chk(eng_req == 1'b1, "R9", "active-low req idle high", eng_req, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule